// File: doc/BRIEF.md
# Millisecond Interval Timer

The block is a free-running periodic interrupt source. Software stores a reload value through a small 32-bit register port. The block then raises an interrupt line every (reload + 1) milliseconds. A prescaler divides the system clock down to a one-millisecond tick. A period counter counts those ticks up to the reload value. When the count matches, the period expires and the next period begins at once.

The interrupt is a level signal that software clears. It clears in one of two ways: by reading the count register, which always returns zero, or by writing a new reload value. A reload write also starts the prescaler and the period counter again from zero. The block needs no re-arming: expiries keep coming whether or not software acknowledges them.

Register offsets are byte addresses, decoded on 32-bit word boundaries (address bits 1:0 are ignored). The reload register is at 0x228 and the count register is at 0x230.

Top module: `ms_interval_timer`

## Requirements
- R1: With reload value N, the interrupt rises exactly (N+1)*CYC_PER_MS clock edges after the edge that accepted the reload write. After reset, with N = 0, the interrupt rises on edge CYC_PER_MS, counting the first edge after reset release as edge 1.
- R2: A write to the reload word (byte offset 0x228) clears the interrupt on that edge and restarts both counters from zero, even when an expiry falls on the same edge.
- R3: After each expiry the next period starts immediately, so expiries repeat every (N+1)*CYC_PER_MS edges whether or not the interrupt was acknowledged.
- R4: A read of the count word (byte offset 0x230) returns zero on reg_rdata after that edge and clears the interrupt.
- R5: After reset the interrupt is low, reg_rdata is zero and the reload value is zero.
- R6: The interrupt is a level output. Once set, it stays high through further expiries until a count read or a reload write clears it.
- R7: When a count read and an expiry fall on the same edge, the expiry wins and the interrupt stays high.
- R8: A read of the reload word returns the stored reload value and does not touch the interrupt. Reads and writes to any other word have no effect on the interrupt or on the timing of expiries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CYC_PER_MS cycles per millisecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | 14 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered on the read edge |
| irq | output | 1 | Interval interrupt, level, active high |

## Verification
The bench sweeps several reload values and measures each first and second expiry to the exact edge. A design that is off by one in the prescaler or in the period compare would expire one edge early or one edge late. The bench also places an acknowledge read exactly on an expiry edge; a design that gives the clear priority would lose that interrupt. It places a reload write on an expiry edge, and issues one in the middle of a period; a design that failed to restart both counters would expire at the old time or leave a stale interrupt set. Accesses to an unrelated word and reads of the reload word must leave a pending interrupt and the period timing alone; a loose address decode would fail these checks.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   localparam int unsigned REG_AW = 14;
   localparam int unsigned REG_DW = 32;
   localparam logic [REG_AW-1:0] OFS_RELOAD = 14'h0228;
   localparam logic [REG_AW-1:0] OFS_COUNT  = 14'h0230;

   typedef struct packed {
      logic restart;    // reload write: clear and restart
      logic ack;        // count read: clear pending interrupt
      logic rd_reload;  // reload read: return stored value
      logic rd_any;     // any read updates reg_rdata
   } itmr_ctl_t;
endpackage

// File: rtl/itmr_decode.sv
module itmr_decode
   import itmr_pkg::*;
(
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_AW-1:0] addr,
   output itmr_ctl_t         ctl
);
   localparam int unsigned WORD_LSB = 2;

   logic hit_reload;
   logic hit_count;

   assign hit_reload = (addr[REG_AW-1:WORD_LSB] == OFS_RELOAD[REG_AW-1:WORD_LSB]);
   assign hit_count  = (addr[REG_AW-1:WORD_LSB] == OFS_COUNT[REG_AW-1:WORD_LSB]);

   always_comb begin
      ctl           = '0;
      ctl.restart   = wr & hit_reload;
      ctl.ack       = rd & hit_count;
      ctl.rd_reload = rd & hit_reload;
      ctl.rd_any    = rd;
   end
endmodule

// File: rtl/itmr_prescale.sv
module itmr_prescale #(
   parameter int unsigned CYC_PER_MS = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic ms_tick
);
   localparam int unsigned PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
   localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

   generate
      if (CYC_PER_MS < 1) begin : g_bad
         $error("itmr_prescale: CYC_PER_MS must be at least 1");
      end else if (CYC_PER_MS == 1) begin : g_direct
         assign ms_tick = ~restart;
      end else begin : g_count
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pcnt <= '0;
            else if (restart)       pcnt <= '0;
            else if (pcnt == LAST)  pcnt <= '0;
            else                    pcnt <= pcnt + 1'b1;
         end
         assign ms_tick = (pcnt == LAST) & ~restart;
      end
   endgenerate
endmodule

// File: rtl/itmr_period.sv
module itmr_period
   import itmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              ms_tick,
   input  logic [REG_DW-1:0] reload,
   output logic              expire
);
   logic [REG_DW-1:0] ms_cnt;
   logic              at_end;

   assign at_end = (ms_cnt == reload);
   assign expire = ms_tick & at_end & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ms_cnt <= '0;
      else if (restart)  ms_cnt <= '0;
      else if (ms_tick)  ms_cnt <= at_end ? '0 : ms_cnt + 1'b1;
   end
endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clear,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq <= 1'b0;
      else if (expire)  irq <= 1'b1;
      else if (clear)   irq <= 1'b0;
   end
endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
   parameter int unsigned CYC_PER_MS = 125000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [13:0] reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq
);
   import itmr_pkg::*;

   itmr_ctl_t         ctl;
   logic [REG_DW-1:0] reload_q;
   logic              ms_tick;
   logic              expire;

   itmr_decode i_decode (
      .wr   (reg_wr),
      .rd   (reg_rd),
      .addr (reg_addr),
      .ctl  (ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           reload_q <= '0;
      else if (ctl.restart) reload_q <= reg_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          reg_rdata <= '0;
      else if (ctl.rd_any) reg_rdata <= ctl.rd_reload ? reload_q : '0;
   end

   itmr_prescale #(.CYC_PER_MS(CYC_PER_MS)) i_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl.restart),
      .ms_tick (ms_tick)
   );

   itmr_period i_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl.restart),
      .ms_tick (ms_tick),
      .reload  (reload_q),
      .expire  (expire)
   );

   itmr_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .clear  (ctl.restart | ctl.ack),
      .irq    (irq)
   );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
   parameter int unsigned CYC_PER_MS = 125000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [13:0] reg_addr,
   input logic [31:0] reg_rdata,
   input logic [31:0] reload,
   input logic        irq
);
   logic        wr_rl;
   logic        rd_ct;
   logic [63:0] since;
   logic [63:0] per;

   assign wr_rl = reg_wr && (reg_addr[13:2] == 12'h08A);
   assign rd_ct = reg_rd && (reg_addr[13:2] == 12'h08C);
   assign per   = (64'(reload) + 64'd1) * 64'(CYC_PER_MS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     since <= '0;
      else if (wr_rl) since <= '0;
      else            since <= since + 64'd1;
   end

   // R1
   period_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (since % per == 64'd0));

   // R2
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rl |=> !irq);

   // R4
   count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ct |=> (reg_rdata == 32'd0));

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_rl && !rd_ct) |=> irq);
endmodule

bind ms_interval_timer itmr_checker #(.CYC_PER_MS(CYC_PER_MS)) i_itmr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .reload    (reload_q),
   .irq       (irq)
);

// File: tb/test_ms_interval_timer.sv
module test_ms_interval_timer;
   localparam int C = 5;
   localparam logic [13:0] A_RELOAD = 14'h0228;
   localparam logic [13:0] A_COUNT  = 14'h0230;
   localparam logic [13:0] A_OTHER  = 14'h0220;
   localparam int NV = 4;
   // {reload, expected period in cycles}
   localparam int VEC [NV][2] = '{'{1, 10}, '{3, 20}, '{0, 5}, '{6, 35}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [13:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   ms_interval_timer #(.CYC_PER_MS(C)) i_ms_interval_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_op(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_op(input logic [13:0] a);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk);
      #1;
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 irq after reset", 32'(irq), 0);
      chk("R5 rdata after reset", reg_rdata, 0);
      rst_n = 1'b1;
      // reload 0 after reset: first expiry at edge C
      edges(C - 1);
      chk("R1 low before first expiry", 32'(irq), 0);
      edges(1);
      chk("R1 first expiry after reset", 32'(irq), 1);
      rd_op(A_RELOAD);
      chk("R5 reload reset value", reg_rdata, 0);
      chk("R8 reload read keeps irq", 32'(irq), 1);
      edges(5);
      chk("R6 irq held across expiry", 32'(irq), 1);
      rd_op(A_COUNT);
      chk("R4 count reads zero", reg_rdata, 0);
      chk("R4 count read clears irq", 32'(irq), 0);
      edges(2);
      chk("R3 low before re-armed expiry", 32'(irq), 0);
      edges(1);
      chk("R3 re-armed expiry", 32'(irq), 1);

      // vector table sweep
      for (int v = 0; v < NV; v++) begin
         wr_op(A_RELOAD, 32'(VEC[v][0]));
         chk("R2 reload write clears irq", 32'(irq), 0);
         edges(VEC[v][1] - 1);
         chk("R1 low one edge before expiry", 32'(irq), 0);
         edges(1);
         chk("R1 expiry at (N+1)*C", 32'(irq), 1);
         rd_op(A_RELOAD);
         chk("R8 reload readback", reg_rdata, 32'(VEC[v][0]));
         edges(1);
         chk("R6 level held", 32'(irq), 1);
         rd_op(A_COUNT);
         chk("R4 ack clears irq", 32'(irq), 0);
         edges(VEC[v][1] - 4);
         chk("R3 low before next expiry", 32'(irq), 0);
         edges(1);
         chk("R3 next expiry one period later", 32'(irq), 1);
      end

      // ack on the expiry edge: expiry wins
      wr_op(A_RELOAD, 32'd1);
      edges(9);
      rd_op(A_COUNT);
      chk("R7 expiry beats ack", 32'(irq), 1);
      chk("R4 count reads zero at collision", reg_rdata, 0);
      rd_op(A_COUNT);
      chk("R4 ack after collision", 32'(irq), 0);
      // reload write on the expiry edge: restart wins
      edges(8);
      wr_op(A_RELOAD, 32'd3);
      chk("R2 write on expiry edge clears", 32'(irq), 0);
      edges(19);
      chk("R2 new period low", 32'(irq), 0);
      edges(1);
      chk("R2 new period expiry", 32'(irq), 1);

      // mid-period restart plus unrelated accesses
      wr_op(A_RELOAD, 32'd1);
      edges(2);
      wr_op(A_OTHER, 32'hFFFF_FFFF);
      edges(2);
      wr_op(A_RELOAD, 32'd1);
      edges(4);
      chk("R2 old expiry suppressed", 32'(irq), 0);
      edges(5);
      chk("R8 other write no shift", 32'(irq), 0);
      edges(1);
      chk("R2 expiry after mid-period restart", 32'(irq), 1);
      rd_op(A_OTHER);
      chk("R8 other read keeps irq", 32'(irq), 1);
      chk("R8 other read data", reg_rdata, 0);

      finish_run();
   end
endmodule